// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Feedback Divider

This block is the feedback path of a frequency synthesizer. It runs on the clock being divided. A two-modulus prescaler, built here as a plain digital counter, divides that clock by either P+1 or P. Two further counters decide which modulus is used. A main counter spans N prescaler periods. A swallow counter keeps the prescaler at P+1 for the first A of those periods. One full output period therefore lasts P*N + A input clocks. At the end of each period the block emits a single comparison pulse for the phase detector.

The divide settings arrive on parallel inputs from a register stage outside this block. The block samples them only when one output period ends and the next begins, so a setting that changes in mid-period never produces a shortened or stretched period. Settings outside the legal range are clamped, and a sticky flag reports that this happened. The prescaler pair is chosen with one select bit. The smaller pair uses P = 2^LOG2_PLO and the larger pair uses twice that value.

Top module: `pulse_swallow_div`

## Requirements
- R1: After the first load, consecutive `fp` pulses are exactly P*N + A clocks apart, where N and A are the clamped values captured at the start of that period.
- R2: `fp` is high for exactly one clock. It rises on the edge that ends a period and never on the first load after reset.
- R3: Counting the load edge as offset 0, `mod_ctl` is 1 while the offset is below A*(P+1) and 0 for the rest of the period. With A = 0 it stays 0 for the whole period.
- R4: `mod_sel` = 1 selects the smaller pair (P = 2^LOG2_PLO, alternate P+1). `mod_sel` = 0 selects the larger pair (P = 2^(LOG2_PLO+1)).
- R5: Changes to `n_set`, `a_set` or `mod_sel` during a period have no effect on that period. They are sampled only on the edge that ends the period.
- R6: A captured `n_set` below 3 is used as 3.
- R7: A captured `a_set` equal to or greater than the effective N is used as N-1.
- R8: `cfg_err` rises on the capture edge that applies either clamp. It then stays high until reset.
- R9: While `rst` is high: `fp` = 0, `mod_ctl` = 1 and `cfg_err` = 0. The first rising clock edge after `rst` is released loads the settings and starts the first period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock being divided |
| rst | input | 1 | Asynchronous reset, active high |
| n_set | input | 11 | Main counter setting N |
| a_set | input | 7 | Swallow counter setting A |
| mod_sel | input | 1 | Prescaler pair select: 1 = small P, 0 = large P |
| fp | output | 1 | One-clock comparison pulse at the end of each period |
| mod_ctl | output | 1 | Modulus control: 1 = divide by P+1, 0 = divide by P |
| cfg_err | output | 1 | Sticky flag: a setting was clamped |

## Verification
The bench instantiates the block with LOG2_PLO = 2. With that value the prescaler pairs are 4/5 and 8/9, so short periods of a few dozen clocks make it possible to check many reloads, mid-period changes and clamp events in a short run. The 11-bit and 7-bit counter widths keep their full size. This allows one period at N = 2047 and A = 127 on the larger pair (16503 clocks) to be checked end to end, which covers the full extent of both counters.

// File: rtl/psd_pkg.sv
package psd_pkg;
    parameter int unsigned NW   = 11;  // main counter width
    parameter int unsigned AW   = 7;   // swallow counter width
    parameter int unsigned NMIN = 3;   // smallest legal main count

    typedef struct packed {
        logic [NW-1:0] n;
        logic [AW-1:0] a;
    } psd_cfg_t;

    typedef struct packed {
        logic          run;
        logic [NW-1:0] n;
        logic [AW-1:0] a;
        logic          mod;
        logic          fp;
    } psd_ctl_t;

    typedef struct packed {
        logic sel;
        logic err;
    } psd_gate_t;
endpackage

// File: rtl/psd_cfg_gate.sv
module psd_cfg_gate
    import psd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [NW-1:0] n_in,
    input  logic [AW-1:0] a_in,
    input  logic          sel_in,
    output psd_cfg_t      cfg_now,
    output logic          sel_q,
    output logic          err_q
);
    psd_gate_t st_d, st_q;
    logic      n_low, a_high;

    always_comb begin
        n_low     = (n_in < NW'(NMIN));
        cfg_now.n = n_low ? NW'(NMIN) : n_in;
        a_high    = (NW'(a_in) >= cfg_now.n);
        cfg_now.a = a_high ? AW'(cfg_now.n - NW'(1)) : a_in;
        st_d      = st_q;
        if (load) begin
            st_d.sel = sel_in;
            if (n_low || a_high) st_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign sel_q = st_q.sel;
    assign err_q = st_q.err;
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler #(
    parameter int unsigned LOG2_PLO = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic sel,
    input  logic mod,
    output logic tick
);
    localparam int unsigned CW      = LOG2_PLO + 2;
    localparam int unsigned P_SMALL = 1 << LOG2_PLO;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [CW-1:0] last;

    always_comb begin
        last  = (sel ? CW'(P_SMALL) : CW'(2 * P_SMALL)) + CW'(mod) - CW'(1);
        tick  = run && (cnt_q == last);
        cnt_d = (!run || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end
endmodule

// File: rtl/psd_cycle_ctl.sv
module psd_cycle_ctl
    import psd_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  psd_cfg_t      cfg_now,
    output logic          load,
    output logic          run,
    output logic          mod,
    output logic          fp,
    output logic [NW-1:0] n_cnt,
    output logic [AW-1:0] a_cnt
);
    psd_ctl_t      st_d, st_q;
    logic [AW-1:0] a_dec;

    always_comb begin
        load   = !st_q.run || (tick && st_q.n == NW'(1));
        a_dec  = st_q.a - AW'(st_q.a != '0);
        st_d    = st_q;
        st_d.fp = 1'b0;
        if (load) begin
            st_d.run = 1'b1;
            st_d.n   = cfg_now.n;
            st_d.a   = cfg_now.a;
            st_d.mod = (cfg_now.a != '0);
            st_d.fp  = st_q.run;
        end else if (tick) begin
            st_d.n   = st_q.n - NW'(1);
            st_d.a   = a_dec;
            st_d.mod = (a_dec != '0);
        end
    end

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            st_q     <= '0;
            st_q.mod <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign run   = st_q.run;
    assign mod   = st_q.mod;
    assign fp    = st_q.fp;
    assign n_cnt = st_q.n;
    assign a_cnt = st_q.a;
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int unsigned LOG2_PLO = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NW-1:0] n_set,
    input  logic [AW-1:0] a_set,
    input  logic          mod_sel,
    output logic          fp,
    output logic          mod_ctl,
    output logic          cfg_err
);
    psd_cfg_t      cfg_now;
    logic          sel_w, load_w, run_w, tick_w;
    logic [NW-1:0] n_cnt;
    logic [AW-1:0] a_cnt;

    psd_cfg_gate u_gate (
        .clk     (clk),
        .rst     (rst),
        .load    (load_w),
        .n_in    (n_set),
        .a_in    (a_set),
        .sel_in  (mod_sel),
        .cfg_now (cfg_now),
        .sel_q   (sel_w),
        .err_q   (cfg_err)
    );

    psd_prescaler #(.LOG2_PLO(LOG2_PLO)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .run  (run_w),
        .sel  (sel_w),
        .mod  (mod_ctl),
        .tick (tick_w)
    );

    psd_cycle_ctl u_ctl (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick_w),
        .cfg_now (cfg_now),
        .load    (load_w),
        .run     (run_w),
        .mod     (mod_ctl),
        .fp      (fp),
        .n_cnt   (n_cnt),
        .a_cnt   (a_cnt)
    );
endmodule

// File: rtl/psd_checker.sv
module psd_checker
    import psd_pkg::*;
(
    input logic          clk,
    input logic          rst,
    input logic          fp,
    input logic          mod_ctl,
    input logic          cfg_err,
    input logic          tick,
    input logic          run,
    input logic [NW-1:0] n_cnt,
    input logic [AW-1:0] a_cnt
);
    AST_FP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        fp |=> !fp);                                          // R2
    AST_FP_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        fp |-> $past(tick));                                  // R1
    AST_MOD_RISE_AT_RELOAD: assert property (@(posedge clk) disable iff (rst)
        $rose(mod_ctl) |-> fp);                               // R3
    AST_COUNTS_LEGAL: assert property (@(posedge clk) disable iff (rst)
        run |-> (n_cnt != '0 && NW'(a_cnt) < n_cnt));         // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_err |=> cfg_err);                                 // R8
endmodule

bind pulse_swallow_div psd_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .fp      (fp),
    .mod_ctl (mod_ctl),
    .cfg_err (cfg_err),
    .tick    (tick_w),
    .run     (run_w),
    .n_cnt   (n_cnt),
    .a_cnt   (a_cnt)
);

// File: tb/pulse_swallow_div_tb.sv
module pulse_swallow_div_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [10:0] n_set = 11'd5;
    logic [6:0]  a_set = 7'd2;
    logic        mod_sel = 1'b1;
    logic        fp, mod_ctl, cfg_err;

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit started = 0;
    int t = 0, len = 0, a_eff = 0, p_eff = 0;
    bit fp_e = 0, mod_e = 1, err_e = 0;

    always #4 clk = ~clk;

    pulse_swallow_div #(.LOG2_PLO(2)) u_dut (
        .clk(clk), .rst(rst), .n_set(n_set), .a_set(a_set),
        .mod_sel(mod_sel), .fp(fp), .mod_ctl(mod_ctl), .cfg_err(cfg_err)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    endtask

    task automatic capture();
        int n;
        int a;
        n = (n_set < 3) ? 3 : int'(n_set);
        a = (int'(a_set) >= n) ? n - 1 : int'(a_set);
        if (n_set < 3 || int'(a_set) >= n) err_e = 1;
        p_eff = mod_sel ? 4 : 8;   // R4
        a_eff = a;
        len   = p_eff * n + a;
    endtask

    task automatic model_step();
        if (!started) begin
            capture();
            started = 1; t = 0; fp_e = 0;
        end else begin
            t++;
            if (t == len) begin
                capture();
                t = 0; fp_e = 1;
            end else begin
                fp_e = 0;
            end
        end
        mod_e = (t < a_eff * (p_eff + 1));
    endtask

    task automatic compare(string tag);
        checks++;
        if (fp !== fp_e) begin
            fails++;
            $display("FAIL %s fp act %0b exp %0b t=%0d", tag, fp, fp_e, t);
        end
        checks++;
        if (mod_ctl !== mod_e) begin
            fails++;
            $display("FAIL %s mod_ctl act %0b exp %0b t=%0d", tag, mod_ctl, mod_e, t);
        end
        checks++;
        if (cfg_err !== err_e) begin
            fails++;
            $display("FAIL %s cfg_err act %0b exp %0b", tag, cfg_err, err_e);
        end
    endtask

    task automatic run_clocks(int n, int a, bit s, int count, string tag);
        for (int k = 0; k < count; k++) begin
            @(negedge clk);
            compare(tag);
            n_set = 11'(n); a_set = 7'(a); mod_sel = s;
            model_step();
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        started = 0; fp_e = 0; mod_e = 1; err_e = 0; t = 0;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            compare("R9");
        end
        rst = 1'b0;
        model_step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        do_reset();                              // R9 reset values, first load
        run_clocks(5, 2, 1'b1, 200, "R1");       // P=4: 22 clock period
        run_clocks(4, 3, 1'b0, 200, "R4");       // P=8: 35 clock period
        run_clocks(3, 0, 1'b1, 100, "R3");       // A=0: no swallow phase
        run_clocks(7, 6, 1'b1, 200, "R2");
        for (int k = 0; k < 80; k++) begin       // R5 settings change mid-period
            int n;
            n = 3 + (k * 7) % 9;
            run_clocks(n, (k * 5) % n, k[0], 5, "R5");
        end
        run_clocks(1, 0, 1'b1, 100, "R6");       // N below 3, clamped
        run_clocks(6, 9, 1'b0, 150, "R7");       // A >= N, clamped to 5
        run_clocks(5, 1, 1'b1, 100, "R8");       // legal again, flag stays set
        do_reset();                              // R9 flag cleared
        run_clocks(2047, 127, 1'b0, 34000, "R1");
        summary();
        $finish;
    end
endmodule